// File: doc/BRIEF.md
# Software Nonvolatile Command Sequence Detector

This block sits beside an asynchronous-style SRAM port and watches the accesses made to it. It looks for a fixed series of six reads. When that series arrives intact, it asks a nonvolatile cycle controller to copy the array into nonvolatile cells (store) or to copy the nonvolatile cells back into the array (recall). The first five addresses are the same for both commands. The sixth address selects which command is issued.

The system clock samples the chip-enable level, and each falling edge of chip-enable counts as one step of the sequence. At that edge the block captures the address and the write-enable level. A write, a read from an unexpected address, or an active busy indication breaks the sequence. A request leaves the block as a pulse one clock wide. No other output exists.

Top module: `nv_seq_detect`

## Requirements
- R1: While reset is asserted and after it is released, both request outputs are low. The detector starts at the first step, so a full six-read sequence is needed before any request.
- R2: The sequence advances only on a falling edge of chip-enable (ce_ni going 1 to 0). Holding chip-enable low while the address changes advances at most one step.
- R3: Reads of 14-bit keys 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, then 0x0FC0, all with we_ni=1, produce one store_req_o pulse. No earlier write is required.
- R4: The same five-key prefix followed by 0x0C63 produces one recall_req_o pulse.
- R5: The output-enable level oe_ni has no effect on the sequence.
- R6: An access with we_ni=0 at any step aborts the sequence, and no request follows from the remaining reads.
- R7: A read whose key does not equal the expected next key aborts the sequence. This includes a sixth key that is neither 0x0FC0 nor 0x0C63.
- R8: Only addr_i[13:0] is compared. addr_i[14] is ignored.
- R9: A read of 0x0E38 that aborts a sequence in progress counts as the first step of a new sequence.
- R10: While busy_i is high the detector returns to the first step and issues no request.
- R11: Each request is high for exactly one clock, store_req_o and recall_req_o are never high together, and a request appears in the second clock after the first rising edge that samples ce_ni low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip-enable level, active low; its falling edge clocks the sequence |
| we_ni | input | 1 | Write-enable level, active low |
| oe_ni | input | 1 | Output-enable level, active low; not used by the detector |
| busy_i | input | 1 | Nonvolatile cycle busy or inhibit, active high |
| addr_i | input | 15 | Access address |
| store_req_o | output | 1 | One-clock store request |
| recall_req_o | output | 1 | One-clock recall request |

## Verification
Clean store and recall sequences show that the sixth key alone selects the command. The same sequences are repeated with output-enable toggling and with address bit 14 set, to show that these inputs have no effect. Sequences broken by a write, by a wrong middle key, by a wrong sixth key or by a busy pulse must yield nothing; each is followed by a clean sequence that must succeed, which separates "aborted" from "stuck". A stray 0x0E38 in mid-sequence and a chip-enable held low across address changes check the restart rule and the edge-only stepping. A cycle-by-cycle sample checks the pulse latency and width.

// File: rtl/nvsd_pkg.sv
package nvsd_pkg;
  localparam int ADDR_W  = 15;
  localparam int KEY_W   = 14;
  localparam int SEQ_LEN = 6;
  localparam int STEP_W  = $clog2(SEQ_LEN);
  localparam int LAST    = SEQ_LEN - 1;

  localparam logic [KEY_W-1:0] STORE_KEY  = 14'h0FC0;
  localparam logic [KEY_W-1:0] RECALL_KEY = 14'h0C63;

  // shared prefix keys, in order of arrival
  function automatic logic [KEY_W-1:0] prefix_key(input int unsigned idx);
    case (idx)
      0:       prefix_key = 14'h0E38;
      1:       prefix_key = 14'h31C7;
      2:       prefix_key = 14'h03E0;
      3:       prefix_key = 14'h3C1F;
      4:       prefix_key = 14'h303F;
      default: prefix_key = '1;
    endcase
  endfunction
endpackage

// File: rtl/nvsd_ce_sampler.sv
module nvsd_ce_sampler #(
  parameter int ADDR_W = nvsd_pkg::ADDR_W,
  parameter int KEY_W  = nvsd_pkg::KEY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_ni,
  input  logic             we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic             ce_fall_o,
  output logic             we_n_o,
  output logic [KEY_W-1:0] key_o
);
  logic ce_s, ce_prev;
  logic [ADDR_W-1:0] addr_s;
  logic unused_addr_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_s    <= 1'b1;
      ce_prev <= 1'b1;
      we_n_o  <= 1'b1;
      addr_s  <= '0;
    end else begin
      ce_s    <= ce_ni;
      ce_prev <= ce_s;
      we_n_o  <= we_ni;
      addr_s  <= addr_i;
    end
  end

  assign ce_fall_o = ce_prev && !ce_s;
  assign key_o     = addr_s[KEY_W-1:0];

  generate
    if (ADDR_W > KEY_W) begin : g_hi
      assign unused_addr_hi = ^addr_s[ADDR_W-1:KEY_W];
    end else begin : g_nohi
      assign unused_addr_hi = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/nvsd_step_fsm.sv
module nvsd_step_fsm
  import nvsd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_fall_i,
  input  logic              we_n_i,
  input  logic              busy_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic [STEP_W-1:0] step_o,
  output logic              store_req_o,
  output logic              recall_req_o
);
  logic [STEP_W-1:0] step_q, step_d;
  logic st_d, rc_d, first_hit, next_hit;

  assign first_hit = (key_i == prefix_key(0));
  assign next_hit  = (key_i == prefix_key(int'(step_q)));

  always_comb begin
    step_d = step_q;
    st_d   = 1'b0;
    rc_d   = 1'b0;
    if (busy_i) begin
      step_d = '0;
    end else if (ce_fall_i) begin
      if (!we_n_i) begin
        step_d = '0;
      end else if (step_q == STEP_W'(LAST)) begin
        if (key_i == STORE_KEY) begin
          st_d   = 1'b1;
          step_d = '0;
        end else if (key_i == RECALL_KEY) begin
          rc_d   = 1'b1;
          step_d = '0;
        end else begin
          step_d = first_hit ? STEP_W'(1) : '0;
        end
      end else if (next_hit) begin
        step_d = step_q + STEP_W'(1);
      end else begin
        step_d = first_hit ? STEP_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q       <= '0;
      store_req_o  <= 1'b0;
      recall_req_o <= 1'b0;
    end else begin
      step_q       <= step_d;
      store_req_o  <= st_d;
      recall_req_o <= rc_d;
    end
  end

  assign step_o = step_q;
endmodule

// File: rtl/nv_seq_detect.sv
module nv_seq_detect
  import nvsd_pkg::*;
#(
  parameter int ADDR_W = nvsd_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              store_req_o,
  output logic              recall_req_o
);
  logic              ce_fall;
  logic              samp_we_n;
  logic [KEY_W-1:0]  samp_key;
  logic [STEP_W-1:0] step;
  logic              unused_oe;

  assign unused_oe = oe_ni; // sequence ignores output enable

  nvsd_ce_sampler #(.ADDR_W(ADDR_W), .KEY_W(KEY_W)) u_samp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_ni     (ce_ni),
    .we_ni     (we_ni),
    .addr_i    (addr_i),
    .ce_fall_o (ce_fall),
    .we_n_o    (samp_we_n),
    .key_o     (samp_key)
  );

  nvsd_step_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ce_fall_i    (ce_fall),
    .we_n_i       (samp_we_n),
    .busy_i       (busy_i),
    .key_i        (samp_key),
    .step_o       (step),
    .store_req_o  (store_req_o),
    .recall_req_o (recall_req_o)
  );
endmodule

// File: rtl/nvsd_checker.sv
module nvsd_checker
  import nvsd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              store_req_o,
  input logic              recall_req_o,
  input logic              ce_fall,
  input logic              samp_we_n,
  input logic [KEY_W-1:0]  samp_key,
  input logic [STEP_W-1:0] step
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(store_req_o && recall_req_o)); // R11
  AST_STORE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |=> !store_req_o); // R11
  AST_RECALL_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_req_o |=> !recall_req_o); // R11
  AST_STORE_ON_EDGE_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |-> $past(ce_fall && samp_we_n && samp_key == STORE_KEY)); // R3
  AST_RECALL_ON_EDGE_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_req_o |-> $past(ce_fall && samp_we_n && samp_key == RECALL_KEY)); // R4
  AST_WRITE_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_fall && !samp_we_n) |=> (step == '0 && !store_req_o && !recall_req_o)); // R6
  AST_BUSY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (step == '0 && !store_req_o && !recall_req_o)); // R10
  AST_NO_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_fall && !busy_i) |=> $stable(step)); // R2
  AST_STEP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step <= STEP_W'(LAST)); // R7
endmodule

bind nv_seq_detect nvsd_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_i       (busy_i),
  .store_req_o  (store_req_o),
  .recall_req_o (recall_req_o),
  .ce_fall      (ce_fall),
  .samp_we_n    (samp_we_n),
  .samp_key     (samp_key),
  .step         (step)
);

// File: tb/sim_nv_seq_detect.sv
`timescale 1ns/1ps
module sim_nv_seq_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, busy = 1'b0;
  logic [14:0] addr = '0;
  logic st, rc;
  int vectors = 0, errors = 0;
  int st_cnt = 0, rc_cnt = 0, both_cnt = 0, long_cnt = 0;
  logic st_prev = 1'b0, rc_prev = 1'b0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  nv_seq_detect u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .busy_i(busy), .addr_i(addr), .store_req_o(st), .recall_req_o(rc)
  );

  always @(negedge clk) begin
    if (st) st_cnt++;
    if (rc) rc_cnt++;
    if (st && rc) both_cnt++;
    if ((st && st_prev) || (rc && rc_prev)) long_cnt++;
    st_prev = st;
    rc_prev = rc;
  end

  function automatic logic [14:0] pk(input int i);
    case (i)
      0: pk = 15'h0E38; 1: pk = 15'h31C7; 2: pk = 15'h03E0;
      3: pk = 15'h3C1F; default: pk = 15'h303F;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic access(input logic [14:0] a, input logic w, input logic o);
    @(negedge clk);
    addr = a; we_n = w; oe_n = o; ce_n = 1'b0;
    @(negedge clk); @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic prefix(input int from, input int upto);
    for (int i = from; i < upto; i++) access(pk(i), 1'b1, 1'b1);
  endtask

  task automatic expect_counts(input string req, input int s0, input int r0,
                               input int es, input int er);
    chk(req, st_cnt - s0, es);
    chk(req, rc_cnt - r0, er);
  endtask

  task automatic t_reset();
    chk("R1 store low in reset", int'(st), 0);
    chk("R1 recall low in reset", int'(rc), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 store low after reset", int'(st), 0);
    chk("R1 recall low after reset", int'(rc), 0);
  endtask

  task automatic t_store();
    int s0 = st_cnt, r0 = rc_cnt;
    prefix(0, 5); access(15'h0FC0, 1'b1, 1'b1);
    expect_counts("R3 store sequence", s0, r0, 1, 0);
  endtask

  task automatic t_recall();
    int s0 = st_cnt, r0 = rc_cnt;
    prefix(0, 5); access(15'h0C63, 1'b1, 1'b1);
    expect_counts("R4 recall sequence", s0, r0, 0, 1);
  endtask

  task automatic t_oe();
    int s0 = st_cnt, r0 = rc_cnt;
    for (int i = 0; i < 5; i++) access(pk(i), 1'b1, i[0]);
    access(15'h0FC0, 1'b1, 1'b0);
    expect_counts("R5 oe toggling ignored", s0, r0, 1, 0);
  endtask

  task automatic t_write();
    int s0 = st_cnt, r0 = rc_cnt;
    prefix(0, 2); access(pk(2), 1'b0, 1'b1); prefix(3, 5);
    access(15'h0FC0, 1'b1, 1'b1);
    expect_counts("R6 write aborts", s0, r0, 0, 0);
    s0 = st_cnt;
    prefix(0, 5); access(15'h0C63, 1'b0, 1'b1);
    expect_counts("R6 write on sixth step", s0, r0, 0, 0);
    prefix(0, 5); access(15'h0C63, 1'b1, 1'b1);
    expect_counts("R6 recovery after write", s0, r0, 0, 1);
  endtask

  task automatic t_mismatch();
    int s0 = st_cnt, r0 = rc_cnt;
    prefix(0, 3); access(15'h1234, 1'b1, 1'b1); prefix(3, 5);
    access(15'h0FC0, 1'b1, 1'b1);
    expect_counts("R7 wrong middle key", s0, r0, 0, 0);
    prefix(0, 5); access(15'h0FC1, 1'b1, 1'b1);
    expect_counts("R7 wrong sixth key", s0, r0, 0, 0);
    prefix(0, 5); access(15'h0FC0, 1'b1, 1'b1);
    expect_counts("R7 recovery after mismatch", s0, r0, 1, 0);
  endtask

  task automatic t_bit14();
    int s0 = st_cnt, r0 = rc_cnt;
    for (int i = 0; i < 5; i++) access(pk(i) | 15'h4000, 1'b1, 1'b1);
    access(15'h4C63, 1'b1, 1'b1);
    expect_counts("R8 address bit 14 ignored", s0, r0, 0, 1);
  endtask

  task automatic t_restart();
    int s0 = st_cnt, r0 = rc_cnt;
    prefix(0, 3); prefix(0, 5); access(15'h0FC0, 1'b1, 1'b1);
    expect_counts("R9 restart on first key", s0, r0, 1, 0);
  endtask

  task automatic t_hold();
    int s0 = st_cnt, r0 = rc_cnt;
    @(negedge clk); addr = pk(0); ce_n = 1'b0;
    for (int i = 1; i < 5; i++) begin
      @(negedge clk); @(negedge clk); addr = pk(i);
    end
    @(negedge clk); @(negedge clk); addr = 15'h0FC0;
    repeat (3) @(negedge clk);
    ce_n = 1'b1; repeat (2) @(negedge clk);
    expect_counts("R2 held chip-enable", s0, r0, 0, 0);
    prefix(1, 5); access(15'h0FC0, 1'b1, 1'b1);
    expect_counts("R2 held low counts once", s0, r0, 1, 0);
  endtask

  task automatic t_busy();
    int s0 = st_cnt, r0 = rc_cnt;
    prefix(0, 3);
    @(negedge clk); busy = 1'b1; repeat (2) @(negedge clk); busy = 1'b0;
    prefix(3, 5); access(15'h0FC0, 1'b1, 1'b1);
    expect_counts("R10 busy pulse clears", s0, r0, 0, 0);
    @(negedge clk); busy = 1'b1;
    prefix(0, 5); access(15'h0C63, 1'b1, 1'b1);
    @(negedge clk); busy = 1'b0;
    expect_counts("R10 busy blocks request", s0, r0, 0, 0);
    prefix(0, 5); access(15'h0FC0, 1'b1, 1'b1);
    expect_counts("R10 recovery after busy", s0, r0, 1, 0);
  endtask

  task automatic t_latency();
    prefix(0, 5);
    @(negedge clk); addr = 15'h0FC0; ce_n = 1'b0;
    @(negedge clk); chk("R11 no pulse after one edge", int'(st), 0);
    @(negedge clk); chk("R11 pulse after two edges", int'(st), 1);
    chk("R11 recall stays low", int'(rc), 0);
    @(negedge clk); chk("R11 pulse one cycle wide", int'(st), 0);
    ce_n = 1'b1; repeat (2) @(negedge clk);
    chk("R11 never both high", both_cnt, 0);
    chk("R11 no long pulse", long_cnt, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_store();
    t_recall();
    t_oe();
    t_write();
    t_mismatch();
    t_bit14();
    t_restart();
    t_hold();
    t_busy();
    t_latency();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule